// File: doc/BRIEF.md
# Walsh-Hadamard Bit-Stream Regenerator

This block takes the eight values that one circuit input receives across eight consecutive test vectors and treats them as a short binary bit-stream. It maps the bits to a bipolar form and correlates the result with the eight Walsh functions of order 3, which yields a signed spectrum. It then discards every spectral coefficient whose magnitude is under a threshold supplied with the stream. An inverse transform rebuilds a bipolar signal from the coefficients that survive, and taking its sign gives a new binary stream. The result is a spectrally filtered test stream. The block also reports the full unpruned spectrum and the position of its strongest component.

A producer offers one stream and one threshold per handshake. Requests move through a four-register pipeline that stalls as a whole whenever a finished result waits at the output. A test pattern generator can use the regenerated stream directly, and it can use the peak index to choose the dominant Walsh component for an input.

Top module: `wht_regen`

## Requirements
- R1: Bit j of `in_stream` is the value at time step j. It counts as s_j = +1 when set and s_j = -1 when clear. The output coefficient k equals the sum over j of s_j·(-1)^popcount(j AND k), for k = 0..7.
- R2: Each coefficient is a two's-complement 5-bit value in the range -8..+8. Coefficient k sits at `out_coefs[5k+4:5k]`, and the reported coefficients are the unpruned spectrum.
- R3: A coefficient whose magnitude is strictly less than `in_thresh` (unsigned, 4 bits) counts as zero in the reconstruction. A coefficient whose magnitude is equal to or greater than the threshold is kept unchanged.
- R4: Bit j of `out_stream` is 1 when the sum over k of c'_k·(-1)^popcount(j AND k) is zero or positive, and 0 when it is negative. Here c'_k are the coefficients that survive pruning.
- R5: With a threshold of 0, `out_stream` equals the accepted `in_stream`.
- R6: With a threshold above 8, every coefficient is removed and `out_stream` is all ones.
- R7: `out_peak` is the index of the coefficient with the largest magnitude in the unpruned spectrum. When several coefficients tie for that magnitude, the lowest index wins.
- R8: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. If `out_ready` stays high, its result shows with `out_valid` high after the third rising edge that follows the accepting edge, and not before. Requests accepted on consecutive edges produce results on consecutive cycles.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and all result ports hold their values and `in_ready` is low. `out_valid` falls only after an edge on which `out_ready` was high.
- R10: After a synchronous reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can take a request this cycle |
| in_stream | input | 8 | Bit-stream, bit j is time step j |
| in_thresh | input | 4 | Pruning magnitude threshold |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_coefs | output | 40 | Eight signed 5-bit coefficients, index k at bits 5k+4..5k |
| out_stream | output | 8 | Regenerated bit-stream |
| out_peak | output | 3 | Index of strongest coefficient |

## Verification
The assertions assume a producer that keeps its request stable and a consumer that obeys the valid/ready rules. They also assume that nothing is sampled while reset is high. The hold and release checks depend on `out_ready` alone, so the bench applies backpressure only through that pin and lets it change only at falling clock edges. Stimulus covers all 256 streams at threshold 0, chosen tie patterns, thresholds on both sides of a coefficient magnitude, and thresholds above 8. Every stream therefore yields coefficients in the -8..+8 range, which is the range the range and peak checks rely on.

// File: rtl/wht_pkg.sv
package wht_pkg;

    localparam int LOG_N = 3;
    localparam int N     = 1 << LOG_N;
    localparam int CW    = LOG_N + 2;      // holds -N..+N
    localparam int TW    = LOG_N + 1;      // threshold width
    localparam int RW    = CW + LOG_N;     // inverse transform accumulator

    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [RW-1:0] acc_t;
    typedef logic        [LOG_N-1:0] idx_t;
    typedef logic        [TW-1:0]    thr_t;
    typedef logic        [N-1:0]     bits_t;
    typedef coef_t spec_t [N];

    localparam coef_t COEF_MAX = coef_t'(N);
    localparam coef_t COEF_MIN = coef_t'(-N);

    // pipeline stage after the forward transform
    typedef struct {
        spec_t raw;
        thr_t  thr;
        bits_t src;
    } fwd_stage_t;

    // pipeline stage after pruning and peak search
    typedef struct {
        spec_t raw;
        spec_t kept;
        idx_t  peak;
        thr_t  thr;
        bits_t src;
    } sel_stage_t;

    function automatic logic [CW-1:0] mag_of(coef_t c);
        return c[CW-1] ? CW'(-c) : CW'(c);
    endfunction

    function automatic logic coefs_in_range(spec_t s);
        for (int k = 0; k < N; k++) begin
            if (s[k] > COEF_MAX || s[k] < COEF_MIN) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic peak_is_max(spec_t s, idx_t p);
        for (int k = 0; k < N; k++) begin
            if (mag_of(s[k]) > mag_of(s[p])) return 1'b0;
            if (k < int'(p) && mag_of(s[k]) == mag_of(s[p])) return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/wht_butterfly.sv
module wht_butterfly #(
    parameter int LOGN = 3,
    parameter int W    = 5
) (
    input  logic signed [W-1:0] x [1<<LOGN],
    output logic signed [W-1:0] y [1<<LOGN]
);
    localparam int NN = 1 << LOGN;

    logic signed [W-1:0] lvl [LOGN+1][NN];

    // Each stage pairs element i with element i + 2^s when bit s of i is
    // clear; the lower slot takes the sum, the upper slot the difference.
    always_comb begin
        lvl[0] = x;
        for (int s = 0; s < LOGN; s++) begin
            for (int i = 0; i < NN; i++) begin
                if (((i >> s) & 1) == 0) begin
                    lvl[s+1][i]          = lvl[s][i] + lvl[s][i + (1 << s)];
                    lvl[s+1][i + (1<<s)] = lvl[s][i] - lvl[s][i + (1 << s)];
                end
            end
        end
    end

    assign y = lvl[LOGN];

endmodule

// File: rtl/wht_prune.sv
module wht_prune
    import wht_pkg::*;
(
    input  spec_t c_in,
    input  thr_t  thr,
    output spec_t c_out
);
    for (genvar k = 0; k < N; k++) begin : g_lane
        assign c_out[k] = (mag_of(c_in[k]) >= CW'(thr)) ? c_in[k] : coef_t'(0);
    end
endmodule

// File: rtl/wht_peak.sv
module wht_peak
    import wht_pkg::*;
(
    input  spec_t c_in,
    output idx_t  peak
);
    logic [CW-1:0] best;

    // strict comparison keeps the earliest index on equal magnitudes
    always_comb begin
        best = mag_of(c_in[0]);
        peak = '0;
        for (int k = 1; k < N; k++) begin
            if (mag_of(c_in[k]) > best) begin
                best = mag_of(c_in[k]);
                peak = idx_t'(k);
            end
        end
    end
endmodule

// File: rtl/wht_regen.sv
module wht_regen
    import wht_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [N-1:0]  in_stream,
    input  logic [TW-1:0] in_thresh,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [N*CW-1:0] out_coefs,
    output logic [N-1:0]  out_stream,
    output logic [LOG_N-1:0] out_peak
);
    logic advance;
    logic v_in, v_fwd, v_sel, v_out;

    bits_t      in_bits_q;
    thr_t       in_thr_q;
    fwd_stage_t fwd_q;
    sel_stage_t sel_q;

    spec_t bipolar, fwd_coef, kept_coef;
    idx_t  peak_idx;
    acc_t  inv_in [N];
    acc_t  inv_out [N];
    bits_t rebuilt;

    spec_t out_coef_q;
    bits_t out_bits_q, out_src_q;
    idx_t  out_peak_q;
    thr_t  out_thr_q;

    // whole pipe freezes while a finished result is refused
    assign advance  = !(v_out && !out_ready);
    assign in_ready = advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_in  <= 1'b0;
            v_fwd <= 1'b0;
            v_sel <= 1'b0;
            v_out <= 1'b0;
        end else if (advance) begin
            v_in  <= in_valid;
            v_fwd <= v_in;
            v_sel <= v_fwd;
            v_out <= v_sel;
        end
    end

    // stage 1: capture
    always_ff @(posedge clk) begin
        if (advance) begin
            in_bits_q <= in_stream;
            in_thr_q  <= in_thresh;
        end
    end

    // stage 2: forward transform on the bipolar stream
    always_comb begin
        for (int j = 0; j < N; j++) begin
            bipolar[j] = in_bits_q[j] ? coef_t'(1) : coef_t'(-1);
        end
    end

    wht_butterfly #(.LOGN(LOG_N), .W(CW)) i_fwd (
        .x (bipolar),
        .y (fwd_coef)
    );

    always_ff @(posedge clk) begin
        if (advance) begin
            fwd_q.raw <= fwd_coef;
            fwd_q.thr <= in_thr_q;
            fwd_q.src <= in_bits_q;
        end
    end

    // stage 3: pruning and peak search
    wht_prune i_prune (
        .c_in  (fwd_q.raw),
        .thr   (fwd_q.thr),
        .c_out (kept_coef)
    );

    wht_peak i_peak (
        .c_in (fwd_q.raw),
        .peak (peak_idx)
    );

    always_ff @(posedge clk) begin
        if (advance) begin
            sel_q.raw  <= fwd_q.raw;
            sel_q.kept <= kept_coef;
            sel_q.peak <= peak_idx;
            sel_q.thr  <= fwd_q.thr;
            sel_q.src  <= fwd_q.src;
        end
    end

    // stage 4: inverse transform; dividing by N keeps the sign, so it is skipped
    always_comb begin
        for (int k = 0; k < N; k++) begin
            inv_in[k] = acc_t'(sel_q.kept[k]);
        end
    end

    wht_butterfly #(.LOGN(LOG_N), .W(RW)) i_inv (
        .x (inv_in),
        .y (inv_out)
    );

    always_comb begin
        for (int j = 0; j < N; j++) begin
            rebuilt[j] = !inv_out[j][RW-1];   // zero counts as a one
        end
    end

    always_ff @(posedge clk) begin
        if (advance) begin
            out_coef_q <= sel_q.raw;
            out_bits_q <= rebuilt;
            out_peak_q <= sel_q.peak;
            out_thr_q  <= sel_q.thr;
            out_src_q  <= sel_q.src;
        end
    end

    assign out_valid  = v_out;
    assign out_stream = out_bits_q;
    assign out_peak   = out_peak_q;

    for (genvar k = 0; k < N; k++) begin : g_pack
        assign out_coefs[k*CW +: CW] = out_coef_q[k];
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_coefs)
            && $stable(out_stream) && $stable(out_peak)); // R9
    AST_RELEASE_ON_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready)); // R9
    AST_COEF_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> coefs_in_range(out_coef_q)); // R2
    AST_PEAK_LARGEST: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> peak_is_max(out_coef_q, out_peak_q)); // R7
    AST_LOSSLESS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_thr_q == '0 |-> out_stream == out_src_q); // R5
    AST_ALL_PRUNED: assert property (@(posedge clk) disable iff (rst)
        out_valid && int'(out_thr_q) > N |-> &out_stream); // R6

endmodule

// File: tb/test_wht_regen.sv
`timescale 1ns/1ps
module test_wht_regen;

    localparam int NB = 8;
    localparam int CB = 5;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic in_ready;
    logic [NB-1:0] in_stream;
    logic [3:0] in_thresh;
    logic out_valid;
    logic out_ready;
    logic [NB*CB-1:0] out_coefs;
    logic [NB-1:0] out_stream;
    logic [2:0] out_peak;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wht_regen i_wht_regen (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_stream(in_stream), .in_thresh(in_thresh),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_coefs(out_coefs), .out_stream(out_stream), .out_peak(out_peak)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int hsign(input int k, input int j);
        return ($countones(k & j) % 2) ? -1 : 1;
    endfunction

    // independent reference from the requirements
    task automatic model(input logic [7:0] st, input int th, output int c[NB],
                         output logic [7:0] ob, output int pk);
        int best;
        for (int k = 0; k < NB; k++) begin
            c[k] = 0;
            for (int j = 0; j < NB; j++) c[k] += (st[j] ? 1 : -1) * hsign(k, j);
        end
        for (int j = 0; j < NB; j++) begin
            int acc = 0;
            for (int k = 0; k < NB; k++) begin
                int m = c[k] < 0 ? -c[k] : c[k];
                if (m >= th) acc += c[k] * hsign(k, j);
            end
            ob[j] = (acc >= 0);
        end
        pk = 0; best = -1;
        for (int k = 0; k < NB; k++) begin
            int m = c[k] < 0 ? -c[k] : c[k];
            if (m > best) begin best = m; pk = k; end
        end
    endtask

    task automatic check_result(input logic [7:0] st, input int th, input string req);
        int c[NB]; logic [7:0] ob; int pk;
        model(st, th, c, ob, pk);
        check(out_valid === 1'b1, "R8", "out_valid", int'(out_valid), 1);
        for (int k = 0; k < NB; k++) begin
            int a = int'($signed(out_coefs[k*CB +: CB]));
            check(a == c[k], "R1/R2", $sformatf("coef %0d of %02h", k, st), a, c[k]);
        end
        check(out_stream == ob, req, $sformatf("stream of %02h thr %0d", st, th),
              int'(out_stream), int'(ob));
        check(int'(out_peak) == pk, "R7", $sformatf("peak of %02h", st), int'(out_peak), pk);
    endtask

    // one request, checking the exact cycle the result shows (R8)
    task automatic run_one(input logic [7:0] st, input int th, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_stream = st; in_thresh = 4'(th);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R8", "early out_valid", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check_result(st, th, req);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_stream = '0; in_thresh = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(out_valid === 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
        check(in_ready === 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_patterns();
        run_one(8'h00, 0, "R4");
        run_one(8'hFF, 0, "R4");
        run_one(8'hA5, 3, "R4");
        run_one(8'h3C, 4, "R4");
        run_one(8'h5D, 6, "R4");
        run_one(8'h96, 2, "R4");
    endtask

    task automatic t_lossless();
        for (int s = 0; s < 256; s++) begin
            run_one(8'(s), 0, "R5");
            check(out_stream == 8'(s), "R5", "identity", int'(out_stream), s);
        end
    endtask

    task automatic t_prune_edge();
        // stream 17h: coefs 1,2,4 are +4, coef 7 is -4, rest 0
        run_one(8'h17, 4, "R3");
        check(out_stream == 8'h17, "R3", "magnitude equal to threshold kept",
              int'(out_stream), 'h17);
        run_one(8'h17, 5, "R3");
        check(out_stream == 8'hFF, "R4", "all removed gives ones",
              int'(out_stream), 'hFF);
    endtask

    task automatic t_all_pruned();
        run_one(8'h00, 9, "R6");
        check(out_stream == 8'hFF, "R6", "thr 9", int'(out_stream), 'hFF);
        run_one(8'h6B, 15, "R6");
        check(out_stream == 8'hFF, "R6", "thr 15", int'(out_stream), 'hFF);
    endtask

    task automatic t_ties();
        run_one(8'h03, 0, "R7");
        check(out_peak == 3'd0, "R7", "tie with index 0", int'(out_peak), 0);
        run_one(8'h17, 0, "R7");
        check(out_peak == 3'd1, "R7", "tie among 1,2,4,7", int'(out_peak), 1);
        run_one(8'h0F, 0, "R7");
        check(out_peak == 3'd4, "R7", "single peak", int'(out_peak), 4);
    endtask

    task automatic t_back_to_back();
        logic [7:0] seq [4] = '{8'h12, 8'hE7, 8'h55, 8'hC0};
        int th [4] = '{0, 2, 4, 6};
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 4) check_result(seq[c-4], th[c-4], "R8");
            if (c < 4) begin
                in_valid = 1'b1; in_stream = seq[c]; in_thresh = 4'(th[c]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(out_valid === 1'b0, "R8", "pipe drained", int'(out_valid), 0);
    endtask

    task automatic t_backpressure();
        logic [7:0] cf; logic [7:0] st;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_stream = 8'h4E; in_thresh = 4'd2;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_result(8'h4E, 2, "R9");
        cf = out_coefs[7:0]; st = out_stream;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b1, "R9", "held valid", int'(out_valid), 1);
        check(in_ready === 1'b0, "R9", "in_ready while held", int'(in_ready), 0);
        check(out_stream == st, "R9", "held stream", int'(out_stream), int'(st));
        check(out_coefs[7:0] == cf, "R9", "held coefs", int'(out_coefs[7:0]), int'(cf));
        check_result(8'h4E, 2, "R9");
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R9", "released", int'(out_valid), 0);
        check(in_ready === 1'b1, "R9", "ready again", int'(in_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_patterns();
        t_prune_edge();
        t_all_pruned();
        t_ties();
        t_back_to_back();
        t_backpressure();
        t_lossless();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule